// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Build-Time Write Policy

This block is a small direct-mapped data cache. It sits between a single-issue CPU port and a slow word-wide RAM. Each line holds one 32-bit word. The line is selected by the low bits of the word address, and the remaining address bits are kept as the tag.

The write policy is fixed by a parameter when the block is built, with three choices:

- write-back;
- write-through, where a write miss goes straight to RAM;
- write-through with allocation, where a write miss first brings the line in.

The CPU holds a request until `cpu_ready` is high for one cycle, which is the cycle the access completes. The cache alone paces every RAM transfer. It holds `mem_en` for a fixed number of cycles and marks the final cycle with `mem_last`. A RAM write commits in that final cycle, and read data is sampled in that cycle too.

Cycle costs follow a fixed latency model, with a RAM transfer of 4 cycles by default:

- a hit costs 1 cycle;
- a RAM read costs 4 cycles, plus 1 cycle to hand the word to the CPU;
- a RAM write costs 4 cycles.

The first RAM cycle overlaps the lookup cycle, so the lookup adds nothing to these costs. A free-running counter advances on every cycle that a request is pending or being serviced, so a scripted run of accesses can be costed from the outside.

Top module: `dm_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses; with no request, `cpu_ready` and `mem_en` are low and the cycle counter reads 0.
- R2: A read hit, or a write hit under write-back (policy 0), raises `cpu_ready` in the same cycle the request is first presented (cost 1). `cpu_ready` is high only while `cpu_req` is high.
- R3: A read miss whose victim needs no write-back costs 5 cycles (4 of RAM read plus 1 of delivery). It returns the RAM word, and a repeat read of that address then hits.
- R4: Under policy 0, a write hit updates only the line and marks it dirty; RAM is left unchanged.
- R5: Under policy 0, a read miss on a valid dirty line writes the old word to its own address in RAM and then fills, costing 9 cycles.
- R6: Under policy 0, a write miss overwrites the line without reading RAM. It costs 1 cycle if the victim is clean or invalid, and 4 cycles if the victim is dirty, in which case the victim is written to RAM first.
- R7: Under policies 1 and 2, a write hit updates both the line and RAM and costs 4 cycles.
- R8: Under policy 1 (write-through, no allocate), a write miss writes RAM in 4 cycles and leaves the line untouched, so a following read of that address misses.
- R9: Under policy 2 (write-through with allocate), a write miss fills the line and then writes RAM, costing 8 cycles; the address then hits.
- R10: Every RAM transfer holds `mem_en`, `mem_we` and `mem_addr` steady for MEM_CYC consecutive cycles, with `mem_last` high only in the final one.
- R11: `acc_cycles` grows by exactly the cost of each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on reads |
| mem_en | output | 1 | RAM transfer in progress |
| mem_we | output | 1 | Transfer is a write |
| mem_last | output | 1 | Final cycle of the transfer (write commit / read sample) |
| mem_addr | output | AW | RAM word address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, sampled on `mem_last` |
| acc_cycles | output | CNT_W | Access-cycle counter |

## Verification
Two functions can share the same cycle. The tag lookup shares its cycle with the first RAM cycle. The last cycle of a victim write-back is also the cycle that decides the next step, which is either a fill or installing the write.

Both overlaps are provoked by sending conflicting addresses to an index that holds a dirty line under write-back. The result is judged in two ways. The exact cycle count must be 9 for a read and 4 for a write. The victim's word must also appear at its own address in the bench RAM, while the new word is returned or retained.

// File: rtl/dm_cache.sv
`timescale 1ns/1ps
module dm_cache #(
  parameter int AW      = 8,
  parameter int LINES   = 4,
  parameter int MEM_CYC = 4,
  parameter int POLICY  = 0,
  parameter int CNT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [31:0]      cpu_wdata,
  output logic             cpu_ready,
  output logic [31:0]      cpu_rdata,
  output logic             mem_en,
  output logic             mem_we,
  output logic             mem_last,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic [CNT_W-1:0] acc_cycles
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;
  localparam int CW = $clog2(MEM_CYC + 1);
  localparam bit IS_WB = (POLICY == 0);
  localparam bit ALLOC = (POLICY != 1);

  typedef enum logic [2:0] {S_IDLE, S_EVICT, S_FILL, S_WRT, S_RESP} state_t;

  state_t state, cur, first_op, after_last;
  logic [CW-1:0] cnt;
  logic [31:0]   line_data [LINES];
  logic [TW-1:0] line_tag  [LINES];
  logic [LINES-1:0] valid_q, dirty_q;

  logic [IW-1:0] idx;
  logic [TW-1:0] ctag;
  logic hit, victim_dirty, quick_done, evict_wr_done, fill_done, wrt_hit, install_wb;

  assign idx  = cpu_addr[IW-1:0];
  assign ctag = cpu_addr[AW-1:IW];
  assign hit  = valid_q[idx] && (line_tag[idx] == ctag);
  assign victim_dirty = IS_WB && valid_q[idx] && dirty_q[idx];

  always_comb begin
    first_op = S_IDLE;
    if (!cpu_we)     first_op = hit ? S_IDLE : (victim_dirty ? S_EVICT : S_FILL);
    else if (hit)    first_op = IS_WB ? S_IDLE : S_WRT;
    else if (IS_WB)  first_op = victim_dirty ? S_EVICT : S_IDLE;
    else             first_op = ALLOC ? S_FILL : S_WRT;
  end

  assign cur = (state == S_IDLE) ? (cpu_req ? first_op : S_IDLE) : state;

  assign mem_en    = (cur == S_EVICT) || (cur == S_FILL) || (cur == S_WRT);
  assign mem_last  = mem_en && (cnt == CW'(MEM_CYC - 1));
  assign mem_we    = (cur == S_EVICT) || (cur == S_WRT);
  assign mem_addr  = (cur == S_EVICT) ? {line_tag[idx], idx} : cpu_addr;
  assign mem_wdata = (cur == S_EVICT) ? line_data[idx] : cpu_wdata;

  assign quick_done    = (state == S_IDLE) && cpu_req && (first_op == S_IDLE);
  assign evict_wr_done = mem_last && (cur == S_EVICT) && cpu_we;
  assign fill_done     = mem_last && (cur == S_FILL);
  assign wrt_hit       = mem_last && (cur == S_WRT) && hit;
  assign install_wb    = (quick_done && cpu_we) || evict_wr_done;

  assign cpu_ready = quick_done || (state == S_RESP) || (mem_last && cur == S_WRT) || evict_wr_done;
  assign cpu_rdata = line_data[idx];

  always_comb begin
    case (cur)
      S_EVICT: after_last = cpu_we ? S_IDLE : S_FILL;
      S_FILL:  after_last = cpu_we ? S_WRT : S_RESP;
      default: after_last = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (mem_en) begin
      if (mem_last) begin
        state <= after_last;
        cnt   <= '0;
      end else begin
        state <= cur;
        cnt   <= cnt + 1'b1;
      end
    end else if (state == S_RESP) begin
      state <= S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (install_wb) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b1;
    end else if (fill_done) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (install_wb || wrt_hit) line_data[idx] <= cpu_wdata;
    else if (fill_done)        line_data[idx] <= cpu_we ? cpu_wdata : mem_rdata;
    if (install_wb || fill_done) line_tag[idx] <= ctag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_cycles <= '0;
    else if (cpu_req || state != S_IDLE) acc_cycles <= acc_cycles + 1'b1;
  end

  assert_last_in_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_last |-> mem_en);
  assert_xfer_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && !mem_last |=> mem_en && $stable(mem_addr) && $stable(mem_we));
  assert_ready_with_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);
  assert_back_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> state == S_IDLE);

  if (POLICY == 0) begin : g_wb_chk
    assert_wb_writes_victims_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en && mem_we |-> mem_addr != cpu_addr);
  end
  if (POLICY == 1) begin : g_wtn_chk
    assert_no_write_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
      state == S_FILL |-> !cpu_we);
  end
endmodule

// File: tb/dm_cache_tb.sv
`timescale 1ns/1ps
module dm_cache_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req [3];
  logic        we  [3];
  logic [7:0]  addr [3];
  logic [31:0] wdat [3];
  logic        rdy [3];
  logic [31:0] rdat [3];
  logic        m_en [3];
  logic        m_we [3];
  logic        m_last [3];
  logic [7:0]  m_addr [3];
  logic [31:0] m_wdata [3];
  logic [31:0] m_rdata [3];
  logic [31:0] acc [3];
  logic [31:0] ram [3][256];

  int checks = 0;
  int fails = 0;
  bit done = 0;

  for (genvar p = 0; p < 3; p++) begin : g_pol
    dm_cache #(.AW(8), .LINES(4), .MEM_CYC(4), .POLICY(p), .CNT_W(32)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(req[p]), .cpu_we(we[p]), .cpu_addr(addr[p]), .cpu_wdata(wdat[p]),
      .cpu_ready(rdy[p]), .cpu_rdata(rdat[p]),
      .mem_en(m_en[p]), .mem_we(m_we[p]), .mem_last(m_last[p]),
      .mem_addr(m_addr[p]), .mem_wdata(m_wdata[p]), .mem_rdata(m_rdata[p]),
      .acc_cycles(acc[p]));
    assign m_rdata[p] = ram[p][m_addr[p]];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 3; p++)
        for (int a = 0; a < 256; a++) ram[p][a] <= 32'hA000_0000 + 32'(a);
    end else begin
      for (int p = 0; p < 3; p++)
        if (m_en[p] && m_we[p] && m_last[p]) ram[p][m_addr[p]] <= m_wdata[p];
    end
  end

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic access(int p, bit w, logic [7:0] a, logic [31:0] d, int exp_cost,
                        bit chk_data, logic [31:0] exp_data, string rq);
    int n;
    logic [31:0] got;
    logic [31:0] c0;
    @(negedge clk);
    c0 = acc[p];
    req[p] = 1'b1; we[p] = w; addr[p] = a; wdat[p] = d;
    n = 0;
    got = '0;
    forever begin
      #1;
      n++;
      if (rdy[p]) begin got = rdat[p]; break; end
      if (n > 40) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 req[p] = 1'b0;
    chk(n == exp_cost, rq, "access cycles", n, exp_cost);
    if (chk_data) chk(got == exp_data, rq, "read data", got, exp_data);
    @(negedge clk);
    chk(acc[p] - c0 == 32'(exp_cost), "R11", "counter delta", acc[p] - c0, exp_cost);
  endtask

  task automatic ram_chk(int p, logic [7:0] a, logic [31:0] exp, string rq);
    @(negedge clk);
    chk(ram[p][a] == exp, rq, "ram word", ram[p][a], exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      chk(!rdy[p] && !m_en[p], "R1", "idle outputs", {rdy[p], m_en[p]}, 0);
      chk(acc[p] == 0, "R1", "counter at reset", acc[p], 0);
    end
    access(0, 0, 8'd5, 0, 5, 1, 32'hA000_0005, "R1");
    access(1, 0, 8'd5, 0, 5, 1, 32'hA000_0005, "R1");
    access(2, 0, 8'd5, 0, 5, 1, 32'hA000_0005, "R3");
  endtask

  task automatic t_write_back();
    access(0, 0, 8'd5, 0, 1, 1, 32'hA000_0005, "R2");
    access(0, 1, 8'd5, 32'h1111_0005, 1, 0, 0, "R4");
    ram_chk(0, 8'd5, 32'hA000_0005, "R4");
    access(0, 0, 8'd5, 0, 1, 1, 32'h1111_0005, "R4");
    access(0, 0, 8'd9, 0, 9, 1, 32'hA000_0009, "R5");
    ram_chk(0, 8'd5, 32'h1111_0005, "R5");
    access(0, 1, 8'd13, 32'h2222_000D, 1, 0, 0, "R6");
    ram_chk(0, 8'd13, 32'hA000_000D, "R6");
    access(0, 1, 8'd17, 32'h3333_0011, 4, 0, 0, "R6");
    ram_chk(0, 8'd13, 32'h2222_000D, "R6");
    access(0, 0, 8'd17, 0, 1, 1, 32'h3333_0011, "R6");
  endtask

  task automatic t_through_noalloc();
    access(1, 1, 8'd6, 32'h4444_0006, 4, 0, 0, "R8");
    ram_chk(1, 8'd6, 32'h4444_0006, "R8");
    access(1, 0, 8'd6, 0, 5, 1, 32'h4444_0006, "R8");
    access(1, 1, 8'd6, 32'h5555_0006, 4, 0, 0, "R7");
    ram_chk(1, 8'd6, 32'h5555_0006, "R7");
    access(1, 0, 8'd6, 0, 1, 1, 32'h5555_0006, "R7");
  endtask

  task automatic t_through_alloc();
    access(2, 1, 8'd7, 32'h6666_0007, 8, 0, 0, "R9");
    ram_chk(2, 8'd7, 32'h6666_0007, "R9");
    access(2, 0, 8'd7, 0, 1, 1, 32'h6666_0007, "R9");
    access(2, 1, 8'd7, 32'h7777_0007, 4, 0, 0, "R7");
    ram_chk(2, 8'd7, 32'h7777_0007, "R7");
    access(2, 0, 8'd11, 0, 5, 1, 32'hA000_000B, "R3");
    access(2, 0, 8'd7, 0, 5, 1, 32'h7777_0007, "R3");
  endtask

  task automatic t_script_total();
    logic [31:0] c0;
    @(negedge clk);
    c0 = acc[0];
    access(0, 1, 8'd20, 32'h8888_0014, 1, 0, 0, "R6");
    access(0, 0, 8'd24, 0, 9, 1, 32'hA000_0018, "R5");
    access(0, 0, 8'd24, 0, 1, 1, 32'hA000_0018, "R2");
    chk(acc[0] - c0 == 32'd11, "R11", "scripted total", acc[0] - c0, 11);
  endtask

  initial begin
    for (int p = 0; p < 3; p++) begin
      req[p] = 0; we[p] = 0; addr[p] = 0; wdat[p] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_write_back();
    t_through_noalloc();
    t_through_alloc();
    t_script_total();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule